// File: doc/BRIEF.md
# Glitch-Safe Clock Mode Switch Controller

This block sequences every change of a processing core's internal clock mode so that no clock glitch can reach the core while it is running. Software writes two small control registers. The first holds a soft power-down request and a halt request, and reports a read-only halted flag. The second holds the requested clock mode, which selects either the direct external clock or the doubled internal clock. A mode request made while the core runs is held pending. It is copied onto the clock-mode select only while the core clock is stopped or the core is halted.

Two safe paths are offered. On the power-down path, the core clock enable drops at once. When the mode changes, the enable is then held low for a settle window of `SETTLE_CYCLES` clock cycles, which is one millisecond at the nominal clock. On the halt path, the output gain ramps down by `GAIN_STEP` on every sample tick until it reaches zero. The core clock then stops and the halted flag is raised. Clearing the halt request restarts the core with full gain, after any settle window still running.

The sequencer has five states: RUN, STOP, SETTLE, RAMP and HALTED. RUN goes to STOP on power-down, and to RAMP on halt. STOP goes to SETTLE on a mode apply, and to RAMP or RUN on release once the settle window has expired. SETTLE restarts itself on a further apply. When it expires, it goes to STOP if power-down is held, to RAMP if halt is held, and to RUN otherwise. RAMP goes to STOP on power-down, to RUN when halt is cleared, and to HALTED when the gain reaches zero. HALTED applies mode changes in place. On release it goes to SETTLE if the window is still running, to STOP if power-down is held, and to RUN otherwise.

Top module: `clkmode_guard`

## Requirements
- R1: After reset the clock enable is 1, the mode select is 0, the gain is all ones, nothing is pending, and both readback bytes are 0.
- R2: With `wr_sel`=0, bit 6 of the write data is the power-down request and bit 3 is the halt request. With `wr_sel`=1, bit 2 is the requested clock mode. All other written bits are ignored and read back as 0. Readback byte A also shows the halted flag on bit 1.
- R3: While power-down has been set for more than one cycle, the core clock enable is 0.
- R4: A mode request written while the core clock runs leaves the mode select unchanged and raises `mode_pending`.
- R5: The mode select changes only while the core clock enable is 0. After each change, the enable stays 0 for at least `SETTLE_CYCLES` cycles, and `mode_pending` clears.
- R6: Releasing power-down with no mode change restores the clock enable within two cycles.
- R7: While halt is requested, the gain never rises. On each sample tick in the ramp it drops by `GAIN_STEP`, saturating at 0, while the clock enable stays 1.
- R8: Once the gain reaches 0 under halt, the halted flag is 1 and the clock enable is 0.
- R9: Clearing halt restarts the core: the clock enable returns to 1, the gain returns to all ones, and the halted flag clears.
- R10: When power-down and halt are both requested, power-down wins. The clock stops and the gain does not ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Target register: 0 selects control A, 1 selects control B |
| wr_data | input | 8 | Write data |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| core_clk_en | output | 1 | Clock enable for the processing core |
| clk_mode_sel | output | 1 | Applied clock mode: 0 is direct, 1 is doubled |
| mode_pending | output | 1 | Requested mode differs from the applied mode |
| gain | output | GAIN_W | Output volume gain |
| ctrl_a_rd | output | 8 | Readback of control A, including the halted flag |
| ctrl_b_rd | output | 8 | Readback of control B |

## Verification
The checker watches a few rules on every cycle. The mode select only moves with the core clock stopped. A change is followed by a full settle window with the enable low, counted by a counter inside the checker. A held power-down keeps the clock stopped, the gain never rises under a held halt, and the halted flag implies zero gain with the clock off. The directed scenarios are needed for the rest. They cover the exact gain sequence on each tick, a pending request taking effect when power-down arrives, a restart after halt restoring full gain, the register bit encodings, and power-down taking priority over a simultaneous halt.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOP,
        ST_SETTLE,
        ST_RAMP,
        ST_HALTED
    } seq_state_t;

    // Bit positions inside the two control bytes
    localparam int A_PDN_BIT    = 6;
    localparam int A_HALT_BIT   = 3;
    localparam int A_HALTED_BIT = 1;
    localparam int B_MODE_BIT   = 2;

endpackage

// File: rtl/cmg_ctrl_regs.sv
module cmg_ctrl_regs
    import cmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       halted,
    output logic       pdn_req,
    output logic       halt_req,
    output logic       mode_req,
    output logic [7:0] rd_a,
    output logic [7:0] rd_b
);

    // Only three bits are stored; the remaining write bits are discarded.
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdn_req  <= 1'b0;
            halt_req <= 1'b0;
            mode_req <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                pdn_req  <= wr_data[A_PDN_BIT];
                halt_req <= wr_data[A_HALT_BIT];
            end else begin
                mode_req <= wr_data[B_MODE_BIT];
            end
        end
    end

    always_comb begin
        rd_a               = '0;
        rd_a[A_PDN_BIT]    = pdn_req;
        rd_a[A_HALT_BIT]   = halt_req;
        rd_a[A_HALTED_BIT] = halted;
        rd_b               = '0;
        rd_b[B_MODE_BIT]   = mode_req;
    end

endmodule

// File: rtl/cmg_settle_timer.sv
module cmg_settle_timer #(
    parameter int SETTLE_CYCLES = 24576
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(SETTLE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/cmg_gain_ramp.sv
module cmg_gain_ramp #(
    parameter int GAIN_W    = 8,
    parameter int GAIN_STEP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              ramp_en,
    input  logic              tick,
    output logic [GAIN_W-1:0] gain,
    output logic              at_zero
);

    localparam logic [GAIN_W-1:0] FULL = '1;
    localparam logic [GAIN_W-1:0] STEP = GAIN_W'(GAIN_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= FULL;
        end else if (restore) begin
            gain <= FULL;
        end else if (ramp_en && tick) begin
            gain <= (gain > STEP) ? (gain - STEP) : '0;
        end
    end

    assign at_zero = (gain == '0);

endmodule

// File: rtl/cmg_seq.sv
module cmg_seq
    import cmg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_req,
    input  logic halt_req,
    input  logic mode_req,
    input  logic timer_expired,
    input  logic gain_zero,
    output logic mode_sel,
    output logic timer_start,
    output logic gain_restore,
    output logic ramp_en,
    output logic core_clk_en,
    output logic halted,
    output logic mode_pending
);

    seq_state_t state, state_nx;
    logic       may_apply;
    logic       apply;

    assign may_apply = (state == ST_STOP) || (state == ST_SETTLE) || (state == ST_HALTED);
    assign apply     = may_apply && (mode_req != mode_sel);

    // State and applied-mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            mode_sel <= 1'b0;
        end else begin
            state <= state_nx;
            if (apply) begin
                mode_sel <= mode_req;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (pdn_req)       state_nx = ST_STOP;
                else if (halt_req) state_nx = ST_RAMP;
            end
            ST_STOP: begin
                if (apply)                           state_nx = ST_SETTLE;
                else if (!pdn_req && timer_expired)  state_nx = halt_req ? ST_RAMP : ST_RUN;
            end
            ST_SETTLE: begin
                if (apply)              state_nx = ST_SETTLE;
                else if (timer_expired) begin
                    if (pdn_req)       state_nx = ST_STOP;
                    else if (halt_req) state_nx = ST_RAMP;
                    else               state_nx = ST_RUN;
                end
            end
            ST_RAMP: begin
                if (pdn_req)        state_nx = ST_STOP;
                else if (!halt_req) state_nx = ST_RUN;
                else if (gain_zero) state_nx = ST_HALTED;
            end
            ST_HALTED: begin
                if (!halt_req && !apply) begin
                    if (!timer_expired) state_nx = ST_SETTLE;
                    else if (pdn_req)   state_nx = ST_STOP;
                    else                state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        core_clk_en  = (state == ST_RUN) || (state == ST_RAMP);
        ramp_en      = (state == ST_RAMP);
        halted       = (state == ST_HALTED);
        timer_start  = apply;
        gain_restore = (state_nx == ST_RUN);
        mode_pending = (mode_req != mode_sel);
    end

endmodule

// File: rtl/clkmode_guard.sv
module clkmode_guard
    import cmg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 24576,
    parameter int GAIN_W        = 8,
    parameter int GAIN_STEP     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              sample_tick,
    output logic              core_clk_en,
    output logic              clk_mode_sel,
    output logic              mode_pending,
    output logic [GAIN_W-1:0] gain,
    output logic [7:0]        ctrl_a_rd,
    output logic [7:0]        ctrl_b_rd
);

    logic pdn_req, halt_req, mode_req;
    logic halted, timer_start, timer_expired;
    logic gain_restore, ramp_en, gain_zero;

    cmg_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .halted   (halted),
        .pdn_req  (pdn_req),
        .halt_req (halt_req),
        .mode_req (mode_req),
        .rd_a     (ctrl_a_rd),
        .rd_b     (ctrl_b_rd)
    );

    cmg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .expired (timer_expired)
    );

    cmg_gain_ramp #(.GAIN_W(GAIN_W), .GAIN_STEP(GAIN_STEP)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restore (gain_restore),
        .ramp_en (ramp_en),
        .tick    (sample_tick),
        .gain    (gain),
        .at_zero (gain_zero)
    );

    cmg_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pdn_req       (pdn_req),
        .halt_req      (halt_req),
        .mode_req      (mode_req),
        .timer_expired (timer_expired),
        .gain_zero     (gain_zero),
        .mode_sel      (clk_mode_sel),
        .timer_start   (timer_start),
        .gain_restore  (gain_restore),
        .ramp_en       (ramp_en),
        .core_clk_en   (core_clk_en),
        .halted        (halted),
        .mode_pending  (mode_pending)
    );

endmodule

// File: rtl/cmg_checker.sv
module cmg_checker
    import cmg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 24576,
    parameter int GAIN_W        = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_clk_en,
    input logic              clk_mode_sel,
    input logic [GAIN_W-1:0] gain,
    input logic [7:0]        ctrl_a_rd
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] since_chg;
    logic          mode_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_chg <= CW'(SETTLE_CYCLES);
            mode_prev <= 1'b0;
        end else begin
            mode_prev <= clk_mode_sel;
            if (clk_mode_sel != mode_prev)          since_chg <= '0;
            else if (since_chg < CW'(SETTLE_CYCLES)) since_chg <= since_chg + 1'b1;
        end
    end

    AST_MODE_CHG_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode_sel != $past(clk_mode_sel)) |-> !core_clk_en); // R5

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_chg < CW'(SETTLE_CYCLES)) |-> !core_clk_en); // R5

    AST_PDN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a_rd[A_PDN_BIT] && $past(ctrl_a_rd[A_PDN_BIT])) |-> !core_clk_en); // R3

    AST_GAIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a_rd[A_HALT_BIT] && $past(ctrl_a_rd[A_HALT_BIT])) |-> (gain <= $past(gain))); // R7

    AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_a_rd[A_HALTED_BIT] |-> (gain == '0 && !core_clk_en)); // R8

endmodule

bind clkmode_guard cmg_checker #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .GAIN_W        (GAIN_W)
) u_cmg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_clk_en  (core_clk_en),
    .clk_mode_sel (clk_mode_sel),
    .gain         (gain),
    .ctrl_a_rd    (ctrl_a_rd)
);

// File: tb/test_clkmode_guard.sv
module test_clkmode_guard;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;
    localparam int GW         = 8;
    localparam int STEP       = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          sample_tick = 1'b0;
    logic          core_clk_en, clk_mode_sel, mode_pending;
    logic [GW-1:0] gain;
    logic [7:0]    ctrl_a_rd, ctrl_b_rd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkmode_guard #(.SETTLE_CYCLES(SETTLE), .GAIN_W(GW), .GAIN_STEP(STEP)) i_clkmode_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .sample_tick  (sample_tick),
        .core_clk_en  (core_clk_en),
        .clk_mode_sel (clk_mode_sel),
        .mode_pending (mode_pending),
        .gain         (gain),
        .ctrl_a_rd    (ctrl_a_rd),
        .ctrl_b_rd    (ctrl_b_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_once;
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 mode_sel", clk_mode_sel, 0);
        chk("R1 gain", gain, 255);
        chk("R1 pending", mode_pending, 0);
        chk("R1 rd_a", ctrl_a_rd, 0);
        chk("R1 rd_b", ctrl_b_rd, 0);
    endtask

    task automatic t_ignored_bits;
        wr(1'b0, 8'hB7);
        wr(1'b1, 8'hFB);
        wait_cyc(2);
        chk("R2 rd_a ignored bits", ctrl_a_rd, 0);
        chk("R2 rd_b ignored bits", ctrl_b_rd, 0);
        chk("R2 clk_en unaffected", core_clk_en, 1);
        chk("R2 no pending", mode_pending, 0);
    endtask

    task automatic t_pdn_plain;
        wr(1'b0, 8'h40);
        chk("R2 rd_a pdn", ctrl_a_rd, 8'h40);
        wait_cyc(2);
        chk("R3 clk stopped", core_clk_en, 0);
        wr(1'b0, 8'h00);
        wait_cyc(2);
        chk("R6 clk restored", core_clk_en, 1);
        chk("R6 mode unchanged", clk_mode_sel, 0);
    endtask

    task automatic t_pending_then_pdn;
        int lows;
        int polls;
        wr(1'b1, 8'h04);
        chk("R2 rd_b mode", ctrl_b_rd, 8'h04);
        wait_cyc(5);
        chk("R4 mode held", clk_mode_sel, 0);
        chk("R4 pending", mode_pending, 1);
        chk("R4 still running", core_clk_en, 1);
        wr(1'b0, 8'h40);
        polls = 0;
        while (clk_mode_sel != 1'b1 && polls < 10) begin
            @(negedge clk);
            polls++;
        end
        chk("R5 mode applied", clk_mode_sel, 1);
        chk("R5 pending cleared", mode_pending, 0);
        chk("R5 clk low at apply", core_clk_en, 0);
        wr(1'b0, 8'h00);
        lows = 0;
        while (core_clk_en == 1'b0 && lows < 100) begin
            @(negedge clk);
            lows++;
        end
        checks++;
        if (lows < SETTLE - 3 || lows > SETTLE + 1) begin
            errors++;
            $display("FAIL R5 settle window: actual %0d expected %0d..%0d", lows, SETTLE - 3, SETTLE + 1);
        end
        chk("R6 running after settle", core_clk_en, 1);
    endtask

    task automatic t_halt_ramp;
        int exp_g;
        wr(1'b0, 8'h08);
        wait_cyc(3);
        exp_g = 255;
        for (int k = 0; k < 8; k++) begin
            tick_once();
            exp_g = (exp_g > STEP) ? exp_g - STEP : 0;
            chk("R7 gain step", gain, exp_g);
            chk("R7 clk on during ramp", core_clk_en, 1);
        end
        wait_cyc(2);
        chk("R8 halted flag", ctrl_a_rd, 8'h0A);
        chk("R8 clk off", core_clk_en, 0);
        chk("R8 gain zero", gain, 0);
        wr(1'b1, 8'h00);
        wait_cyc(3);
        chk("R5 applied while halted", clk_mode_sel, 0);
        chk("R5 pending cleared halted", mode_pending, 0);
        wr(1'b0, 8'h00);
        wait_cyc(2);
        chk("R5 settle after halt", core_clk_en, 0);
        wait_cyc(SETTLE + 6);
        chk("R9 restart clk", core_clk_en, 1);
        chk("R9 gain full", gain, 255);
        chk("R9 flags clear", ctrl_a_rd, 0);
    endtask

    task automatic t_priority;
        wr(1'b0, 8'h48);
        wait_cyc(3);
        chk("R10 clk off", core_clk_en, 0);
        tick_once();
        tick_once();
        chk("R10 no ramp", gain, 255);
        chk("R10 not halted", ctrl_a_rd, 8'h48);
        wr(1'b0, 8'h00);
        wait_cyc(3);
        chk("R10 released", core_clk_en, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_ignored_bits();
        t_pdn_plain();
        t_pending_then_pdn();
        t_halt_ramp();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule